// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control sequencer of a small accumulator machine. A read-only control store holds 20-bit microinstructions. A micro program counter selects the word to execute, and a microinstruction buffer holds it for one clock while the decoder turns it into microorder lines for the datapath. The decoder also drives a 3-bit function code to the arithmetic unit. The datapath registers, the arithmetic unit and the memory sit outside the block. They act on the microorder lines in the cycle those lines are asserted, and they return the instruction-register opcode, an interrupt request and a memory-ready handshake.

Each microinstruction is either an order word or a branch word, as bit 0 shows. An order word issues its microorders and then lets the micro program counter advance by one. A branch word issues no orders. It loads the micro program counter with the 8-bit target held in bits [9:2]. When bit 1 is set, it instead loads the address of the current opcode's routine, or of the interrupt-initiation routine if an interrupt is pending.

The store is laid out as follows. Opcode k starts at address k*8. The instruction-fetch routine starts at 0x20, interrupt initiation at 0x28 and the reset vector at 0x30. Opcodes are 0 no-operation, 1 complement, 2 add from memory and 3 load from memory.

Top module: `useq_ctrl`

## Requirements
- R1: While reset is high, the micro program counter is forced to the reset vector 0x30 and no microorder is asserted. The fetch routine's orders appear in the first cycle after reset falls.
- R2: The fetch word asserts exactly PC-to-address-bus, memory-to-data-bus, memory-read, load-IR and increment-PC, with function code 000.
- R3: After an order word that is not stalled, the micro program counter advances by exactly one.
- R4: A branch word with bit 1 clear loads the micro program counter with its bits [9:2].
- R5: A branch word with bit 1 set and no interrupt pending loads the micro program counter with opcode*8. The next cycle shows that opcode's first word.
- R6: A branch word with bit 1 set while the interrupt request is high goes to 0x28. There, interrupt-acknowledge alone is asserted for one cycle, followed by a branch back to fetch.
- R7: Opcode 1 issues function code 101 with load-X, then result-to-data-bus with load-accumulator.
- R8: Opcode 2 issues IR-address-to-address-bus, memory-to-data-bus, memory-read, load-X and function code 001, then result-to-data-bus with load-accumulator.
- R9: Opcode 3 issues IR-address-to-address-bus, memory-to-data-bus, memory-read and load-accumulator in a single word.
- R10: Opcode 0 branches straight back to fetch without asserting any microorder.
- R11: While memory-read is asserted and memory-ready is low, the micro program counter and every output hold their values.
- R12: A cycle that executes a branch word drives every microorder and the function code to zero.
- R13: Every opcode routine ends with a branch to 0x20, so the fetch orders follow that branch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 2 | Opcode field of the instruction register |
| irq_i | input | 1 | Interrupt pending, sampled by the dispatch branch |
| mem_ready_i | input | 1 | Memory can complete the current read |
| pc_abus_o | output | 1 | Drive PC onto the address bus |
| ir_abus_o | output | 1 | Drive IR address field onto the address bus |
| mem_dbus_o | output | 1 | Drive memory onto the data bus |
| mem_rd_o | output | 1 | Memory read |
| ld_ir_o | output | 1 | Load instruction register |
| inc_pc_o | output | 1 | Increment PC |
| fu_dbus_o | output | 1 | Drive function-unit result onto the data bus |
| ld_x_o | output | 1 | Load the X register |
| ld_acc_o | output | 1 | Load the accumulator |
| irq_ack_o | output | 1 | Interrupt acknowledge |
| fn_o | output | 3 | Function code to the arithmetic unit |

## Verification
The assertions assume that the datapath keeps the opcode stable during the dispatch cycle. They also assume that memory-ready is asserted eventually, since a read that never completes stalls the sequencer for good. Finally, they assume that the interrupt request stays high until the acknowledge appears. The bench keeps to all three. It sets the opcode and the interrupt line before each fetch and clears the interrupt only in the acknowledge cycle. It holds memory-ready low for 0, 1 or 2 cycles on every read word and then raises it. It sweeps all four opcodes, each with and without a pending interrupt.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UW      = 20;
    localparam int UPC_W   = 8;
    localparam int OPC_W   = 2;
    localparam int RGN_W   = 3;
    localparam int FN_W    = 3;
    localparam int NORD    = 10;
    localparam int PAD_W   = UW - FN_W - NORD;
    localparam int BR_BIT  = 0;
    localparam int DSP_BIT = 1;
    localparam int TGT_LSB = 2;
    localparam int BRZ_W   = UW - UPC_W - 2;

    localparam logic [UPC_W-1:0] FETCH_A = 8'h20;
    localparam logic [UPC_W-1:0] INTR_A  = 8'h28;
    localparam logic [UPC_W-1:0] RSTV_A  = 8'h30;

    localparam logic [FN_W-1:0] FN_NOP = 3'b000;
    localparam logic [FN_W-1:0] FN_ADD = 3'b001;
    localparam logic [FN_W-1:0] FN_NOT = 3'b101;

    typedef struct packed {
        logic pc_abus;
        logic ir_abus;
        logic mem_dbus;
        logic mem_rd;
        logic ld_ir;
        logic inc_pc;
        logic fu_dbus;
        logic ld_x;
        logic ld_acc;
        logic irq_ack;
    } ord_t;

    localparam ord_t O_FETCH = '{pc_abus: 1'b1, mem_dbus: 1'b1, mem_rd: 1'b1,
                                 ld_ir: 1'b1, inc_pc: 1'b1, default: 1'b0};
    localparam ord_t O_LDX   = '{ld_x: 1'b1, default: 1'b0};
    localparam ord_t O_RES   = '{fu_dbus: 1'b1, ld_acc: 1'b1, default: 1'b0};
    localparam ord_t O_RDX   = '{ir_abus: 1'b1, mem_dbus: 1'b1, mem_rd: 1'b1,
                                 ld_x: 1'b1, default: 1'b0};
    localparam ord_t O_LOAD  = '{ir_abus: 1'b1, mem_dbus: 1'b1, mem_rd: 1'b1,
                                 ld_acc: 1'b1, default: 1'b0};
    localparam ord_t O_ACK   = '{irq_ack: 1'b1, default: 1'b0};

    function automatic logic [UPC_W-1:0] region_base(input logic [OPC_W-1:0] op);
        return UPC_W'(op) << RGN_W;
    endfunction

    function automatic logic [UW-1:0] mk_op(input logic [FN_W-1:0] fn, input ord_t o);
        return {fn, o, {PAD_W{1'b0}}};
    endfunction

    function automatic logic [UW-1:0] mk_br(input logic dsp, input logic [UPC_W-1:0] tgt);
        return {{BRZ_W{1'b0}}, tgt, dsp, 1'b1};
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  logic [UPC_W-1:0] addr,
    output logic [UW-1:0]    word
);
    localparam logic [UPC_W-1:0] NOP_A = region_base(2'd0);
    localparam logic [UPC_W-1:0] NOT_A = region_base(2'd1);
    localparam logic [UPC_W-1:0] ADD_A = region_base(2'd2);
    localparam logic [UPC_W-1:0] LD_A  = region_base(2'd3);

    always_comb begin
        case (addr)
            NOP_A:              word = mk_br(1'b0, FETCH_A);
            NOT_A:              word = mk_op(FN_NOT, O_LDX);
            NOT_A + 8'd1:       word = mk_op(FN_NOP, O_RES);
            NOT_A + 8'd2:       word = mk_br(1'b0, FETCH_A);
            ADD_A:              word = mk_op(FN_ADD, O_RDX);
            ADD_A + 8'd1:       word = mk_op(FN_NOP, O_RES);
            ADD_A + 8'd2:       word = mk_br(1'b0, FETCH_A);
            LD_A:               word = mk_op(FN_NOP, O_LOAD);
            LD_A + 8'd1:        word = mk_br(1'b0, FETCH_A);
            FETCH_A:            word = mk_op(FN_NOP, O_FETCH);
            FETCH_A + 8'd1:     word = mk_br(1'b1, '0);
            INTR_A:             word = mk_op(FN_NOP, O_ACK);
            INTR_A + 8'd1:      word = mk_br(1'b0, FETCH_A);
            RSTV_A:             word = mk_br(1'b0, FETCH_A);
            default:            word = mk_br(1'b0, FETCH_A);
        endcase
    end
endmodule

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
(
    input  logic [UW-1:0]    word,
    output ord_t             ord,
    output logic [FN_W-1:0]  fn,
    output logic             is_br,
    output logic             dsp,
    output logic [UPC_W-1:0] tgt
);
    always_comb begin
        is_br = word[BR_BIT];
        dsp   = word[DSP_BIT];
        tgt   = word[TGT_LSB +: UPC_W];
        if (is_br) begin
            ord = '0;
            fn  = FN_NOP;
        end else begin
            ord = word[PAD_W +: NORD];
            fn  = word[UW-1 -: FN_W];
        end
    end
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  logic [UPC_W-1:0] upc,
    input  logic             is_br,
    input  logic             dsp,
    input  logic [UPC_W-1:0] tgt,
    input  logic [OPC_W-1:0] opcode,
    input  logic             irq,
    output logic [UPC_W-1:0] nxt
);
    always_comb begin
        if (!is_br)
            nxt = upc + 8'd1;
        else if (!dsp)
            nxt = tgt;
        else if (irq)
            nxt = INTR_A;
        else
            nxt = region_base(opcode);
    end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic             irq_i,
    input  logic             mem_ready_i,
    output logic             pc_abus_o,
    output logic             ir_abus_o,
    output logic             mem_dbus_o,
    output logic             mem_rd_o,
    output logic             ld_ir_o,
    output logic             inc_pc_o,
    output logic             fu_dbus_o,
    output logic             ld_x_o,
    output logic             ld_acc_o,
    output logic             irq_ack_o,
    output logic [FN_W-1:0]  fn_o
);
    logic [UPC_W-1:0] upc, nxt, rom_addr, tgt;
    logic [UW-1:0]    ubuf, rom_q;
    ord_t             ord;
    logic [FN_W-1:0]  fn;
    logic             is_br, dsp, hold;

    useq_decode u_dec (
        .word  (ubuf),
        .ord   (ord),
        .fn    (fn),
        .is_br (is_br),
        .dsp   (dsp),
        .tgt   (tgt)
    );

    useq_next u_nxt (
        .upc    (upc),
        .is_br  (is_br),
        .dsp    (dsp),
        .tgt    (tgt),
        .opcode (opcode_i),
        .irq    (irq_i),
        .nxt    (nxt)
    );

    assign hold     = ord.mem_rd & ~mem_ready_i;
    assign rom_addr = rst ? RSTV_A : (hold ? upc : nxt);

    useq_store u_rom (
        .addr (rom_addr),
        .word (rom_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            upc  <= RSTV_A;
            ubuf <= rom_q;
        end else begin
            upc  <= rom_addr;
            ubuf <= rom_q;
        end
    end

    assign pc_abus_o  = ord.pc_abus;
    assign ir_abus_o  = ord.ir_abus;
    assign mem_dbus_o = ord.mem_dbus;
    assign mem_rd_o   = ord.mem_rd;
    assign ld_ir_o    = ord.ld_ir;
    assign inc_pc_o   = ord.inc_pc;
    assign fu_dbus_o  = ord.fu_dbus;
    assign ld_x_o     = ord.ld_x;
    assign ld_acc_o   = ord.ld_acc;
    assign irq_ack_o  = ord.irq_ack;
    assign fn_o       = fn;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
    import useq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [OPC_W-1:0] opcode_i,
    input logic             irq_i,
    input logic             mem_ready_i,
    input logic [UPC_W-1:0] upc,
    input logic [UPC_W-1:0] tgt,
    input logic             is_br,
    input logic             dsp,
    input logic             mem_rd_o,
    input logic [12:0]      outs
);
    AST_RST_VEC: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (upc == RSTV_A && outs == '0)); // R1

    AST_SEQ_INC: assert property (@(posedge clk) disable iff (rst)
        (!is_br && !(mem_rd_o && !mem_ready_i)) |=> (upc == $past(upc) + 8'd1)); // R3

    AST_BR_TGT: assert property (@(posedge clk) disable iff (rst)
        (is_br && !dsp) |=> (upc == $past(tgt))); // R4

    AST_DISPATCH: assert property (@(posedge clk) disable iff (rst)
        (is_br && dsp && !irq_i) |=> (upc == region_base($past(opcode_i)))); // R5

    AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (is_br && dsp && irq_i) |=> (upc == INTR_A)); // R6

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && !mem_ready_i) |=> ($stable(upc) && $stable(outs))); // R11

    AST_BR_QUIET: assert property (@(posedge clk) disable iff (rst)
        is_br |-> (outs == '0)); // R12
endmodule

bind useq_ctrl useq_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .opcode_i    (opcode_i),
    .irq_i       (irq_i),
    .mem_ready_i (mem_ready_i),
    .upc         (upc),
    .tgt         (tgt),
    .is_br       (is_br),
    .dsp         (dsp),
    .mem_rd_o    (mem_rd_o),
    .outs        ({fn_o, pc_abus_o, ir_abus_o, mem_dbus_o, mem_rd_o, ld_ir_o,
                   inc_pc_o, fu_dbus_o, ld_x_o, ld_acc_o, irq_ack_o})
);

// File: tb/useq_ctrl_bench.sv
module useq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] opcode = 2'd0;
    logic       irq = 1'b0;
    logic       ready = 1'b1;
    logic       pc_abus, ir_abus, mem_dbus, mem_rd, ld_ir, inc_pc;
    logic       fu_dbus, ld_x, ld_acc, irq_ack;
    logic [2:0] fn;
    logic [12:0] obs;
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // expected {fn[2:0], pc_abus, ir_abus, mem_dbus, mem_rd, ld_ir, inc_pc, fu_dbus, ld_x, ld_acc, irq_ack}
    localparam logic [12:0] E_NONE  = 13'b000_0000000000;
    localparam logic [12:0] E_FETCH = 13'b000_1011110000;
    localparam logic [12:0] E_NOT0  = 13'b101_0000000100;
    localparam logic [12:0] E_RES   = 13'b000_0000001010;
    localparam logic [12:0] E_ADD0  = 13'b001_0111000100;
    localparam logic [12:0] E_LOAD  = 13'b000_0111000010;
    localparam logic [12:0] E_ACK   = 13'b000_0000000001;

    always #2.5 clk = ~clk;

    useq_ctrl u_useq_ctrl (
        .clk (clk), .rst (rst), .opcode_i (opcode), .irq_i (irq),
        .mem_ready_i (ready),
        .pc_abus_o (pc_abus), .ir_abus_o (ir_abus), .mem_dbus_o (mem_dbus),
        .mem_rd_o (mem_rd), .ld_ir_o (ld_ir), .inc_pc_o (inc_pc),
        .fu_dbus_o (fu_dbus), .ld_x_o (ld_x), .ld_acc_o (ld_acc),
        .irq_ack_o (irq_ack), .fn_o (fn)
    );

    assign obs = {fn, pc_abus, ir_abus, mem_dbus, mem_rd, ld_ir, inc_pc,
                  fu_dbus, ld_x, ld_acc, irq_ack};

    task automatic check(input logic [12:0] exp, input string rq);
        tests++;
        if (obs !== exp) begin
            fails++;
            $display("FAIL %s: outputs %b, expected %b", rq, obs, exp);
        end
    endtask

    // one microinstruction, optionally stretched by holding ready low
    task automatic step(input logic [12:0] exp, input string rq, input int stalls);
        for (int s = 0; s <= stalls; s++) begin
            @(negedge clk);
            check(exp, (s > 0) ? "R11" : rq);
            ready = (s == stalls);
        end
    endtask

    task automatic run_instr(input logic [1:0] op, input logic with_irq, input int st);
        opcode = op;
        irq    = with_irq;
        step(E_FETCH, "R2", st);
        step(E_NONE, "R12", 0);
        if (with_irq) begin
            step(E_ACK, "R6", 0);
            irq = 1'b0;
            step(E_NONE, "R6", 0);
        end else begin
            case (op)
                2'd0: step(E_NONE, "R10", 0);
                2'd1: begin
                    step(E_NOT0, "R5/R7", 0);
                    step(E_RES, "R3/R7", 0);
                    step(E_NONE, "R4/R13", 0);
                end
                2'd2: begin
                    step(E_ADD0, "R5/R8", st);
                    step(E_RES, "R3/R8", 0);
                    step(E_NONE, "R4/R13", 0);
                end
                default: begin
                    step(E_LOAD, "R5/R9", st);
                    step(E_NONE, "R4/R13", 0);
                end
            endcase
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(E_NONE, "R1");
        rst = 1'b0;
        check(E_NONE, "R1");
        for (int st = 0; st < 3; st++)
            for (int ir = 0; ir < 2; ir++)
                for (int op = 0; op < 4; op++)
                    run_instr(2'(op), 1'(ir), st);
        // reset in the middle of a routine
        opcode = 2'd2;
        step(E_FETCH, "R2", 0);
        step(E_NONE, "R12", 0);
        rst = 1'b1;
        @(negedge clk);
        check(E_NONE, "R1");
        @(negedge clk);
        check(E_NONE, "R1");
        rst = 1'b0;
        step(E_FETCH, "R1", 0);
        step(E_NONE, "R12", 0);
        step(E_ADD0, "R8", 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule